// File: doc/BRIEF.md
# Four-Voice Programmable Tone and Noise Generator

This block produces the raw waveforms of a small sound generator: three square-wave tone voices and one noise voice. A host programs it one byte at a time over a single byte stream. Each byte is decoded by its top bits into one of three kinds: an attenuation setting for a voice, a "latch" byte that carries the low period nibble of a voice, or a follow-on byte that carries the upper six period bits. A follow-on byte always goes to the voice named by the most recent latch byte.

A fixed prescaler divides the system clock by 16 to make a tick. Each tone voice counts ticks down from its 10-bit period and flips its square wave when the count runs out. The noise voice clocks a 16-bit shift register at one of three fixed tick rates, or on every flip of tone voice 2. It runs either as a rotating single bit (periodic mode) or as a tapped feedback sequence (noise mode). Each voice drives a 1-bit waveform flag and a 4-bit level. The level is the loudness (15 minus the attenuation) while the waveform is high, and zero while it is low. Mixing and conversion to analog happen outside this block.

Byte stream rules: a byte is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low during reset and rises at the first clock edge after reset is released. After that it stays high, so the block never applies back-pressure. Bytes of the form `01xxxxxx` are accepted and discarded. A follow-on byte is also discarded when the last latched voice is the noise voice.

Top module: `psg_core`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, every bit of `voice_level` and `voice_on` is 0. Every attenuation resets to 15, every period resets to 0, and the last latched voice resets to voice 0.
- R2: A byte `1 v v 1 a a a a` sets the attenuation of voice `vv` to `aaaa`. It does not change the last latched voice. Voice `v` drives level bits `[4v+3:4v]`. That field equals 15 − `aaaa` while `voice_on[v]` is 1, and 0 while `voice_on[v]` is 0.
- R3: A byte `1 v v 0 p p p p` with `vv` < 3 sets bits 3:0 of the period of voice `vv`. With any `vv`, it records `vv` as the last latched voice. A byte `0 0 h h h h h h` sets bits 9:4 of the period of the last latched tone voice. The periods of the other voices do not change.
- R4: A tone voice with period P (1..1023) flips `voice_on[v]` every P×16 clock cycles. A new period takes effect at the next flip.
- R5: A tone period of 0 behaves exactly like a period of 1: the voice flips every 16 cycles.
- R6: An attenuation of 15 holds the voice's level field at 0, while its `voice_on` waveform keeps running.
- R7: A latch byte to voice 3 (`1110 0 m r r`) writes the noise control and restarts the shift register at 0x8000. Control bit 2 is `m`: 0 selects periodic, 1 selects noise. Bits 1:0 are `rr`. In periodic mode the register rotates right, so `voice_on[3]` is high for one shift out of every 16. Rate codes 0, 1 and 2 shift once every 256, 512 and 1024 clock cycles.
- R8: In noise mode each shift moves the register right by one. The new bit 15 is bit 0 XOR bit 3, and `voice_on[3]` shows bit 0.
- R9: With rate code 3, the shift register advances once on each flip of tone voice 2, and at no other time.
- R10: `wr_ready` is 1 on every cycle after the first clock edge following reset release, so every byte presented with `wr_valid` high is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command byte present |
| wr_ready | output | 1 | Block can take a byte (high after reset) |
| wr_data | input | 8 | Command byte |
| voice_level | output | 16 | Four 4-bit gated levels, voice v at bits [4v+3:4v] |
| voice_on | output | 4 | Per-voice waveform enable, voices 0-2 tone, 3 noise |

## Verification
A misrouted byte shows as a voice whose flip interval or level changes when it should not. A stale last-voice latch shows the same way, and both appear within one or two half-periods of that voice. A wrong tone down-counter or prescaler stretches or shortens the measured flip interval by whole multiples of 16 cycles, starting at the first reload after the write. A noise register with a bad tap, seed or shift rate goes out of step with the expected bit sequence within a few shift intervals after the control write. A gating error shows as a nonzero level while the waveform is low, or a level that does not match the attenuation while it is high.

// File: rtl/psg_pkg.sv
package psg_pkg;

  localparam int NUM_VOICES = 4;
  localparam int NUM_TONES  = 3;
  localparam int PER_W      = 10;
  localparam int LO_W       = 4;
  localparam int HI_W       = PER_W - LO_W;
  localparam int ATT_W      = 4;
  localparam int SEL_W      = $clog2(NUM_VOICES);
  localparam logic [SEL_W-1:0] NOISE_SEL = SEL_W'(NUM_VOICES - 1);

  typedef enum logic [1:0] {
    BK_IGNORE,
    BK_ATTEN,
    BK_LATCH,
    BK_HIGH
  } byte_kind_e;

  typedef struct packed {
    logic       noisy;
    logic [1:0] rate;
  } noise_ctl_t;

  function automatic byte_kind_e classify(input logic [7:0] b);
    if (b[7])           return b[4] ? BK_ATTEN : BK_LATCH;
    else if (!b[6])     return BK_HIGH;
    else                return BK_IGNORE;
  endfunction

endpackage

// File: rtl/psg_prescale.sv
module psg_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // a tick is a single-cycle pulse when dividing (R4)
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/psg_regs.sv
module psg_regs
  import psg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [7:0]                       wr_byte,
  output logic [NUM_VOICES-1:0][ATT_W-1:0] atten,
  output logic [NUM_TONES-1:0][PER_W-1:0]  period,
  output noise_ctl_t                       noise_ctl,
  output logic                             noise_wr
);

  byte_kind_e        kind;
  logic [SEL_W-1:0]  sel;
  logic [SEL_W-1:0]  last_sel;

  assign kind     = classify(wr_byte);
  assign sel      = wr_byte[6:5];
  assign noise_wr = wr_en && (kind == BK_LATCH) && (sel == NOISE_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      atten     <= '1;
      period    <= '0;
      last_sel  <= '0;
      noise_ctl <= '0;
    end else if (wr_en) begin
      case (kind)
        BK_ATTEN: begin
          for (int v = 0; v < NUM_VOICES; v++)
            if (sel == SEL_W'(v)) atten[v] <= wr_byte[ATT_W-1:0];
        end
        BK_LATCH: begin
          last_sel <= sel;
          if (sel == NOISE_SEL) begin
            noise_ctl <= noise_ctl_t'(wr_byte[2:0]);
          end else begin
            for (int t = 0; t < NUM_TONES; t++)
              if (sel == SEL_W'(t)) period[t][LO_W-1:0] <= wr_byte[LO_W-1:0];
          end
        end
        BK_HIGH: begin
          for (int t = 0; t < NUM_TONES; t++)
            if (last_sel == SEL_W'(t)) period[t][PER_W-1:LO_W] <= wr_byte[HI_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // attenuation only moves on an attenuation byte (R2)
  assert_atten_only_on_vol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && kind == BK_ATTEN) |=> $stable(atten));

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_keep
    // a follow-on byte leaves the periods of other voices alone (R3)
    assert_other_period_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == BK_HIGH && last_sel != SEL_W'(t)) |=> $stable(period[t]));
  end

endmodule

// File: rtl/psg_tone.sv
module psg_tone
  import psg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             wave,
  output logic             flip
);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] reload;

  assign reload = (period == '0) ? PER_W'(1) : period;
  assign flip   = tick && (cnt <= PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (tick) begin
      if (cnt <= PER_W'(1)) begin
        cnt  <= reload;
        wave <= ~wave;
      end else begin
        cnt  <= cnt - 1'b1;
      end
    end
  end

  // the waveform only moves on a prescaler tick (R4)
  assert_wave_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave));

  // the down-counter never holds zero once it has been loaded (R5)
  assert_no_zero_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> cnt != '0);

endmodule

// File: rtl/psg_noise.sv
module psg_noise
  import psg_pkg::*;
#(
  parameter int LFSR_W    = 16,
  parameter int TAP       = 3,
  parameter int RATE_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tone_flip,
  input  logic       ctl_wr,
  input  noise_ctl_t ctl,
  output logic       wave
);
  localparam int DIV_W = RATE_LOG2 + 2;
  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  logic [DIV_W-1:0]  div_cnt;
  logic [DIV_W-1:0]  div_last;
  logic [LFSR_W-1:0] lfsr;
  logic              shift;
  logic              fb;

  always_comb begin
    div_last = '0;
    for (int r = 0; r < 3; r++)
      if (ctl.rate == 2'(r)) div_last = DIV_W'((1 << (RATE_LOG2 + r)) - 1);
  end

  assign shift = (ctl.rate == 2'd3) ? tone_flip : (tick && div_cnt == div_last);
  assign fb    = ctl.noisy ? (lfsr[0] ^ lfsr[TAP]) : lfsr[0];
  assign wave  = lfsr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      lfsr    <= SEED;
    end else if (ctl_wr) begin
      div_cnt <= '0;
      lfsr    <= SEED;
    end else begin
      if (tick) div_cnt <= (div_cnt == div_last) ? '0 : div_cnt + 1'b1;
      if (shift) lfsr <= {fb, lfsr[LFSR_W-1:1]};
    end
  end

  // periodic mode keeps exactly one bit circulating (R7)
  assert_single_bit_periodic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.noisy |-> $countones(lfsr) == 1);

  // tapped feedback never locks up in the all-zero state (R8)
  assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // tone-clocked rate holds still between tone-2 flips (R9)
  assert_hold_between_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rate == 2'd3 && !tone_flip && !ctl_wr) |=> $stable(lfsr));

endmodule

// File: rtl/psg_core.sv
module psg_core
  import psg_pkg::*;
#(
  parameter int PRESCALE  = 16,
  parameter int LFSR_W    = 16,
  parameter int NOISE_TAP = 3,
  parameter int RATE_LOG2 = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [7:0]                  wr_data,
  output logic [NUM_VOICES*ATT_W-1:0] voice_level,
  output logic [NUM_VOICES-1:0]       voice_on
);

  logic                             tick;
  logic                             wr_en;
  logic [NUM_VOICES-1:0][ATT_W-1:0] atten;
  logic [NUM_TONES-1:0][PER_W-1:0]  period;
  noise_ctl_t                       noise_ctl;
  logic                             noise_wr;
  logic [NUM_VOICES-1:0]            wave;
  logic [NUM_TONES-1:0]             tone_flip;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  assign wr_en = wr_valid && wr_ready;

  psg_prescale #(.DIV(PRESCALE)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  psg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_byte   (wr_data),
    .atten     (atten),
    .period    (period),
    .noise_ctl (noise_ctl),
    .noise_wr  (noise_wr)
  );

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
    psg_tone u_tone (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .period (period[t]),
      .wave   (wave[t]),
      .flip   (tone_flip[t])
    );

    // every reload of a tone counter flips its output (R4)
    assert_flip_moves_wave_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tone_flip[t] |=> voice_on[t] != $past(voice_on[t]));
  end

  psg_noise #(
    .LFSR_W    (LFSR_W),
    .TAP       (NOISE_TAP),
    .RATE_LOG2 (RATE_LOG2)
  ) u_noise (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tone_flip (tone_flip[NUM_TONES-1]),
    .ctl_wr    (noise_wr),
    .ctl       (noise_ctl),
    .wave      (wave[NUM_VOICES-1])
  );

  assign voice_on = wave;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_level
    assign voice_level[v*ATT_W +: ATT_W] = wave[v] ? ~atten[v] : '0;

    // full attenuation silences the voice (R6)
    assert_full_atten_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (atten[v] == '1) |-> voice_level[v*ATT_W +: ATT_W] == '0);
  end

  // once up, the byte port never stalls (R10)
  assert_ready_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready);

endmodule

// File: tb/psg_core_bench.sv
module psg_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_ready;
  logic [15:0] voice_level;
  logic [3:0]  voice_on;

  int cycle = 0;
  int checks = 0;
  int errors = 0;

  psg_core u_psg_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_data     (wr_data),
    .voice_level (voice_level),
    .voice_on    (voice_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (cycle > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cycle, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] lfsr_next(input logic [15:0] s, input logic noisy);
    logic nb;
    nb = noisy ? (s[0] ^ s[3]) : s[0];
    return {nb, s[15:1]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_att(input int v, input logic [3:0] a);
    wr({1'b1, 2'(v), 1'b1, a});
  endtask

  task automatic set_period(input int v, input logic [9:0] p);
    wr({1'b1, 2'(v), 1'b0, p[3:0]});
    wr({2'b00, p[9:4]});
  endtask

  task automatic wait_change(input int v, output int t);
    logic prev;
    int n;
    prev = voice_on[v];
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (voice_on[v] == prev && n < 40000);
    t = cycle;
  endtask

  task automatic half_period(input int v, output int hp);
    int t0, t1;
    wait_change(v, t0);
    wait_change(v, t1);
    hp = t1 - t0;
  endtask

  task automatic level_scan(input int v, input int a, input int n, input string tag);
    int bad, act, expv;
    bad = 0; act = 0; expv = 0;
    for (int k = 0; k < n; k++) begin
      int e;
      @(negedge clk);
      e = voice_on[v] ? (15 - a) : 0;
      if (int'(voice_level[v*4 +: 4]) != e) begin
        if (bad == 0) begin act = int'(voice_level[v*4 +: 4]); expv = e; end
        bad++;
      end
    end
    check(bad == 0, tag, act, expv);
  endtask

  task automatic noise_timed(input logic [2:0] ctl, input int n, input string tag);
    int s_len, bad, act, expv;
    logic [15:0] m;
    s_len = 16 * (16 << ctl[1:0]);
    bad = 0; act = 0; expv = 0;
    wr({5'b11100, ctl});
    m = 16'h8000;
    repeat (s_len + s_len/2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      m = lfsr_next(m, ctl[2]);
      if (voice_on[3] !== m[0]) begin
        if (bad == 0) begin act = int'(voice_on[3]); expv = int'(m[0]); end
        bad++;
      end
      repeat (s_len) @(negedge clk);
    end
    check(bad == 0, tag, act, expv);
  endtask

  task automatic noise_toned(input logic noisy, input int n, input string tag);
    int t, bad, act, expv;
    logic [15:0] m;
    bad = 0; act = 0; expv = 0;
    wait_change(2, t);
    wr({5'b11100, noisy, 2'b11});
    m = 16'h8000;
    for (int k = 0; k < n; k++) begin
      wait_change(2, t);
      m = lfsr_next(m, noisy);
      if (voice_on[3] !== m[0]) begin
        if (bad == 0) begin act = int'(voice_on[3]); expv = int'(m[0]); end
        bad++;
      end
    end
    check(bad == 0, tag, act, expv);
  endtask

  initial begin
    int hp, t;
    void'($urandom(32'd4660));

    repeat (4) @(negedge clk);
    check(voice_level == 16'h0 && voice_on == 4'h0, "R1 levels in reset",
          int'(voice_level), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(voice_level == 16'h0 && voice_on == 4'h0, "R1 levels after reset",
          int'({voice_on, voice_level}), 0);
    check(wr_ready == 1'b1, "R10 ready after reset", int'(wr_ready), 1);

    // R5: default period 0 flips every 16 cycles
    half_period(0, hp);
    check(hp == 16, "R5 period zero", hp, 16);

    // R2 directed: full loudness on voice 0
    set_att(0, 4'd0);
    level_scan(0, 0, 64, "R2 loud voice0");

    // R4/R3 directed routing
    set_period(0, 10'd5);
    half_period(0, hp);
    check(hp == 80, "R4 voice0 period 5", hp, 80);
    set_period(1, 10'h041);
    half_period(1, hp);
    check(hp == 1040, "R3 voice1 high bits", hp, 1040);
    half_period(0, hp);
    check(hp == 80, "R3 voice0 untouched", hp, 80);

    // R3: attenuation byte between latch and follow-on keeps the latch
    wr(8'b1100_0011);       // latch voice 2, low nibble 3
    set_att(0, 4'd2);       // volume byte to voice 0
    wr(8'b0000_0010);       // high bits 2 -> period 0x023
    half_period(2, hp);
    check(hp == 560, "R3 latch survives volume byte", hp, 560);
    half_period(1, hp);
    check(hp == 1040, "R3 voice1 untouched", hp, 1040);
    check(wr_ready == 1'b1, "R10 ready held", int'(wr_ready), 1);

    // R6: full attenuation, waveform still running
    set_period(1, 10'd2);
    set_att(1, 4'hF);
    half_period(1, hp);
    check(hp == 32, "R6 voice1 still toggling", hp, 32);
    level_scan(1, 15, 96, "R6 voice1 silent");

    // random tones: R4 and R2
    for (int it = 0; it < 8; it++) begin
      int v, p, a;
      v = $urandom_range(0, 2);
      p = $urandom_range(1, 24);
      a = $urandom_range(0, 14);
      set_att(v, 4'(a));
      set_period(v, 10'(p));
      half_period(v, hp);
      check(hp == p * 16, "R4 random period", hp, p * 16);
      level_scan(v, a, 3 * p * 16, "R2 random level");
    end

    // noise voice
    noise_timed(3'b000, 20, "R7 periodic rate0");
    noise_timed(3'b110, 24, "R8 noise rate2");
    noise_timed(3'b101, 24, "R8 noise rate1");
    noise_timed(3'b010, 18, "R7 periodic rate2");
    noise_timed(3'b001, 18, "R7 periodic rate1");

    set_period(2, 10'd3);
    wait_change(2, t);
    noise_toned(1'b0, 34, "R9 periodic on tone2");
    noise_toned(1'b1, 40, "R9 noise on tone2");

    set_att(3, 4'd5);
    level_scan(3, 5, 400, "R2 noise level");
    check(wr_ready == 1'b1, "R10 ready at end", int'(wr_ready), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule